// File: doc/BRIEF.md
# Capability load result filter

This block sits behind the memory read of a capability-sized load. It takes the returned word and its validity tag and decides what the destination capability register receives. It also decides whether the instruction takes a fault and whether a load-reserved variant sets a reservation. Address translation supplies a three-way disposition for the page: pass the tag through under the authorising permission, strip the tag, or fault when a tagged word is actually loaded.

Every accepted read response produces exactly one result, registered one cycle later. That result is one of three things: a register write, a load-capability page fault, or the report of a memory exception from the read itself. A retire strobe and a success flag go with it. Fault and exception reports share one address and cause bus. The page-fault cause code is a parameter.

Top module: `lc_filter`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, wr_en_o, resv_set_o, lc_fault_o, mem_exc_o and retire_o are all low.
- R2: When disp_i is 2'b00 (pass), the register is written with rsp_data_i. wr_tag_o is rsp_tag_i ANDed with auth_lc_perm_i, and retire_ok_o is high.
- R3: When disp_i is 2'b01 (strip), the register is written with rsp_data_i. wr_tag_o is 0 whatever the loaded tag, and retire_ok_o is high.
- R4: When disp_i is 2'b10 (fault) and rsp_tag_i is 1, lc_fault_o is raised with fault_vaddr_o equal to vaddr_i and fault_cause_o equal to LC_FAULT_CAUSE. wr_en_o stays low and retire_ok_o is low. auth_lc_perm_i has no effect on this outcome.
- R5: When disp_i is 2'b10 and rsp_tag_i is 0, the register is written with rsp_data_i and wr_tag_o is 0. retire_ok_o is high.
- R6: resv_set_o is high, with resv_addr_o equal to vaddr_i, exactly when lr_i is 1 and the load writes the register. It stays low when the load faults, when a memory exception is reported, or when lr_i is 0.
- R7: mem_exc_i takes precedence over every disposition. mem_exc_o is raised with fault_vaddr_o equal to vaddr_i and fault_cause_o equal to mem_exc_cause_i. Nothing is written, no reservation is set, and retire_ok_o is low.
- R8: Every cycle with rsp_valid_i high yields exactly one of wr_en_o, lc_fault_o or mem_exc_o, together with retire_o, on the next cycle. Back-to-back responses are accepted. With rsp_valid_i low, none of them is raised on the next cycle.
- R9: The unused disposition code 2'b11 behaves exactly like 2'b10 (fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | DATA_W | Loaded capability bits |
| rsp_tag_i | input | 1 | Loaded validity tag |
| mem_exc_i | input | 1 | The read raised a memory exception |
| mem_exc_cause_i | input | CAUSE_W | Cause code of that exception |
| vaddr_i | input | VADDR_W | Access virtual address |
| auth_lc_perm_i | input | 1 | Load-capability permission of the authorising capability |
| disp_i | input | 2 | Page disposition: 00 pass, 01 strip, 10 fault, 11 fault |
| lr_i | input | 1 | Load-reserved variant |
| wr_en_o | output | 1 | Destination register write |
| wr_data_o | output | DATA_W | Write data |
| wr_tag_o | output | 1 | Written tag |
| resv_set_o | output | 1 | Set reservation |
| resv_addr_o | output | VADDR_W | Reservation address |
| lc_fault_o | output | 1 | Load-capability page fault request |
| mem_exc_o | output | 1 | Memory exception report |
| fault_vaddr_o | output | VADDR_W | Faulting virtual address |
| fault_cause_o | output | CAUSE_W | Fault cause code |
| retire_o | output | 1 | Instruction retires this cycle |
| retire_ok_o | output | 1 | Retire succeeded |

## Verification
Every result (write, tag, reservation, fault, exception, address, cause and retire) is due exactly one clock edge after the response is presented. Stimulus is driven on the falling edge. Outputs are sampled on the next falling edge, after the single capturing rising edge, so each sample shows one response's result. A back-to-back pair is checked the same way on consecutive falling edges. Idle cycles are checked to confirm that no stray strobe appears.

// File: rtl/lc_filter_pkg.sv
package lc_filter_pkg;
  typedef enum logic [1:0] {
    LC_PASS  = 2'b00,
    LC_STRIP = 2'b01,
    LC_FAULT = 2'b10,
    LC_RSVD  = 2'b11
  } lc_disp_e;

  typedef struct packed {
    logic wr_en;
    logic wr_tag;
    logic resv;
    logic lc_fault;
    logic mem_exc;
    logic ok;
  } lc_res_t;
endpackage

// File: rtl/lc_filter_decide.sv
module lc_filter_decide
  import lc_filter_pkg::*;
(
  input  logic       valid_i,
  input  logic       tag_i,
  input  logic       perm_i,
  input  logic [1:0] disp_i,
  input  logic       lr_i,
  input  logic       exc_i,
  output lc_res_t    res_o
);
  always_comb begin
    res_o = '0;
    if (valid_i) begin
      if (exc_i) begin
        res_o.mem_exc = 1'b1;
      end else begin
        unique case (lc_disp_e'(disp_i))
          LC_PASS: begin
            res_o.wr_en  = 1'b1;
            res_o.wr_tag = tag_i & perm_i;
            res_o.resv   = lr_i;
            res_o.ok     = 1'b1;
          end
          LC_STRIP: begin
            res_o.wr_en = 1'b1;
            res_o.resv  = lr_i;
            res_o.ok    = 1'b1;
          end
          default: begin
            // fault only when a tagged word arrives; reserved code aliases here
            if (tag_i) begin
              res_o.lc_fault = 1'b1;
            end else begin
              res_o.wr_en = 1'b1;
              res_o.resv  = lr_i;
              res_o.ok    = 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lc_filter_stage.sv
module lc_filter_stage
  import lc_filter_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VADDR_W = 39,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  lc_res_t            res_d_i,
  input  logic [DATA_W-1:0]  data_d_i,
  input  logic [VADDR_W-1:0] vaddr_d_i,
  input  logic [CAUSE_W-1:0] cause_d_i,
  output lc_res_t            res_q_o,
  output logic [DATA_W-1:0]  data_q_o,
  output logic [VADDR_W-1:0] vaddr_q_o,
  output logic [CAUSE_W-1:0] cause_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q_o <= '0;
    else         res_q_o <= res_d_i;
  end

  // payload only moves on a response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o  <= '0;
      vaddr_q_o <= '0;
      cause_q_o <= '0;
    end else if (valid_i) begin
      data_q_o  <= data_d_i;
      vaddr_q_o <= vaddr_d_i;
      cause_q_o <= cause_d_i;
    end
  end
endmodule

// File: rtl/lc_filter.sv
module lc_filter
  import lc_filter_pkg::*;
#(
  parameter int unsigned          DATA_W         = 64,
  parameter int unsigned          VADDR_W        = 39,
  parameter int unsigned          CAUSE_W        = 6,
  parameter logic [CAUSE_W-1:0]   LC_FAULT_CAUSE = 6'h1c
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rsp_valid_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  input  logic               rsp_tag_i,
  input  logic               mem_exc_i,
  input  logic [CAUSE_W-1:0] mem_exc_cause_i,
  input  logic [VADDR_W-1:0] vaddr_i,
  input  logic               auth_lc_perm_i,
  input  logic [1:0]         disp_i,
  input  logic               lr_i,
  output logic               wr_en_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               wr_tag_o,
  output logic               resv_set_o,
  output logic [VADDR_W-1:0] resv_addr_o,
  output logic               lc_fault_o,
  output logic               mem_exc_o,
  output logic [VADDR_W-1:0] fault_vaddr_o,
  output logic [CAUSE_W-1:0] fault_cause_o,
  output logic               retire_o,
  output logic               retire_ok_o
);
  lc_res_t            res_d, res_q;
  logic [CAUSE_W-1:0] cause_d;
  logic [VADDR_W-1:0] vaddr_q;

  assign cause_d = mem_exc_i ? mem_exc_cause_i : LC_FAULT_CAUSE;

  lc_filter_decide i_decide (
    .valid_i (rsp_valid_i),
    .tag_i   (rsp_tag_i),
    .perm_i  (auth_lc_perm_i),
    .disp_i  (disp_i),
    .lr_i    (lr_i),
    .exc_i   (mem_exc_i),
    .res_o   (res_d)
  );

  lc_filter_stage #(
    .DATA_W  (DATA_W),
    .VADDR_W (VADDR_W),
    .CAUSE_W (CAUSE_W)
  ) i_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rsp_valid_i),
    .res_d_i   (res_d),
    .data_d_i  (rsp_data_i),
    .vaddr_d_i (vaddr_i),
    .cause_d_i (cause_d),
    .res_q_o   (res_q),
    .data_q_o  (wr_data_o),
    .vaddr_q_o (vaddr_q),
    .cause_q_o (fault_cause_o)
  );

  assign wr_en_o       = res_q.wr_en;
  assign wr_tag_o      = res_q.wr_tag;
  assign resv_set_o    = res_q.resv;
  assign resv_addr_o   = vaddr_q;
  assign lc_fault_o    = res_q.lc_fault;
  assign mem_exc_o     = res_q.mem_exc;
  assign fault_vaddr_o = vaddr_q;
  assign retire_o      = res_q.wr_en | res_q.lc_fault | res_q.mem_exc;
  assign retire_ok_o   = res_q.ok;

  assert_one_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> $countones({wr_en_o, lc_fault_o, mem_exc_o}) == 1);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_i |=> !retire_o);

  assert_exc_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && mem_exc_i) |=> (mem_exc_o && !retire_ok_o && !resv_set_o));

  assert_strip_tag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !mem_exc_i && disp_i == LC_STRIP) |=> (wr_en_o && !wr_tag_o));

  assert_trap_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !mem_exc_i && disp_i[1] && rsp_tag_i) |=> (lc_fault_o && !wr_en_o));

  assert_resv_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_set_o |-> (wr_en_o && retire_ok_o));

  assert_ok_matches_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_ok_o |-> wr_en_o);
endmodule

// File: tb/test_lc_filter.sv
module test_lc_filter;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned VADDR_W = 39;
  localparam int unsigned CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] LCC = 6'h1c;

  // [11] exc [10] lr [9:8] disp [7] tag [6] perm | [5] wr [4] wtag [3] resv [2] flt [1] mexc [0] ok
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    12'b0_0_00_1_1_110001,
    12'b0_1_00_1_0_101001,
    12'b0_0_00_0_1_100001,
    12'b0_1_01_1_1_101001,
    12'b0_0_01_1_1_100001,
    12'b0_1_10_1_1_000100,
    12'b0_0_10_1_0_000100,
    12'b0_1_10_0_0_101001,
    12'b1_1_00_1_1_000010,
    12'b1_0_10_1_1_000010,
    12'b1_1_01_1_1_000010,
    12'b0_0_11_1_1_000100,
    12'b0_1_11_0_0_101001
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rsp_valid = 0, rsp_tag = 0, mem_exc = 0, perm = 0, lr = 0;
  logic [DATA_W-1:0]  rsp_data = '0;
  logic [CAUSE_W-1:0] exc_cause = '0;
  logic [VADDR_W-1:0] vaddr = '0;
  logic [1:0]         disp = '0;
  logic wr_en, wr_tag, resv, lc_fault, mexc, retire, ok;
  logic [DATA_W-1:0]  wr_data;
  logic [VADDR_W-1:0] resv_addr, f_vaddr;
  logic [CAUSE_W-1:0] f_cause;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lc_filter #(.DATA_W(DATA_W), .VADDR_W(VADDR_W), .CAUSE_W(CAUSE_W), .LC_FAULT_CAUSE(LCC)) i_lc_filter (
    .clk_i(clk), .rst_ni(rst_n), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .rsp_tag_i(rsp_tag), .mem_exc_i(mem_exc), .mem_exc_cause_i(exc_cause), .vaddr_i(vaddr),
    .auth_lc_perm_i(perm), .disp_i(disp), .lr_i(lr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .wr_tag_o(wr_tag), .resv_set_o(resv), .resv_addr_o(resv_addr), .lc_fault_o(lc_fault),
    .mem_exc_o(mexc), .fault_vaddr_o(f_vaddr), .fault_cause_o(f_cause), .retire_o(retire),
    .retire_ok_o(ok)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [11:0] v);
    if (v[11])             return "R7";
    if (v[9:8] == 2'b11)   return "R9";
    if (v[9:8] == 2'b10)   return v[7] ? "R4" : "R5";
    if (v[9:8] == 2'b01)   return "R3";
    return "R2";
  endfunction

  task automatic drive(input logic [11:0] v, input int idx);
    rsp_valid = 1'b1;
    mem_exc   = v[11];
    lr        = v[10];
    disp      = v[9:8];
    rsp_tag   = v[7];
    perm      = v[6];
    rsp_data  = 64'hC0DE_5A00_0000_0000 | 64'(idx);
    vaddr     = 39'h40_0000_1000 + 39'(idx * 16);
    exc_cause = 6'h05 + 6'(idx);
  endtask

  task automatic expect_row(input logic [11:0] v, input int idx);
    string r;
    r = req_of(v);
    chk(r, 64'({wr_en, wr_tag, resv, lc_fault, mexc, ok}), 64'(v[5:0]));
    chk("R8", 64'({retire, $countones({wr_en, lc_fault, mexc})}), 64'({1'b1, 32'd1}));
    chk("R6", 64'(resv), 64'(v[10] & v[5]));
    if (v[5]) chk(r, wr_data, 64'hC0DE_5A00_0000_0000 | 64'(idx));
    if (v[3]) chk("R6", 64'(resv_addr), 64'(39'h40_0000_1000 + 39'(idx * 16)));
    if (v[2]) chk("R4", 64'({f_vaddr, f_cause}), 64'({39'h40_0000_1000 + 39'(idx * 16), LCC}));
    if (v[1]) chk("R7", 64'({f_vaddr, f_cause}),
                  64'({39'h40_0000_1000 + 39'(idx * 16), 6'h05 + 6'(idx)}));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 64'({wr_en, resv, lc_fault, mexc, retire}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'({wr_en, resv, lc_fault, mexc, retire}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], i);
      @(negedge clk);
      rsp_valid = 1'b0;
      expect_row(VEC[i], i);
      @(negedge clk);
      chk("R8", 64'({wr_en, lc_fault, mexc, retire}), 64'd0);
    end

    // back-to-back: fault then pass write
    drive(VEC[5], 5);
    @(negedge clk);
    expect_row(VEC[5], 5);
    drive(VEC[1], 1);
    @(negedge clk);
    rsp_valid = 1'b0;
    expect_row(VEC[1], 1);

    // R4: permission irrelevant to fault, tag set + perm both ways already; idle with garbage inputs
    mem_exc = 1'b1; disp = 2'b10; rsp_tag = 1'b1;
    @(negedge clk);
    chk("R8", 64'({wr_en, lc_fault, mexc, retire}), 64'd0);
    @(negedge clk);
    finish_run();
  end
endmodule